// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block gathers up to 128 interrupt request lines and steers each one into one or more of 15 ranked groups. Software assigns lines to groups with per-word membership bitmaps. Each line also has its own enable, input inversion and sleep-wake enable bit. Each group records a pending flag. The flag is set either by the level of its combined request or only by a rising edge of that request, and it stays set until software writes the group's number to an acknowledge register.

The controller raises one interrupt output while any unmasked group is pending. It reports the best group, which is the lowest-numbered pending unmasked group. Inside that group it also reports the highest-numbered live line. Per-group status words show software which lines are live. A separate wake output is purely combinational, so it works while the core sleeps and no clock edge is needed.

All registers are 32-bit words on a simple synchronous register bus. Writes take effect at the clock edge. Reads are combinational from the address.

Top module: `gpi_ctrl`

## Requirements
- R1: After a synchronous reset, the enable, sleep-wake, membership, group-mask, group-level and group-wake registers read zero. The inversion registers read the POL_DEFAULT parameter (zero by default). irq_out and cause_vld are low, and the cause register reads zero.
- R2: A line's live value is its raw input XOR its inversion bit. Inversion registers are at 0x08 + word. An inverted line with a low input shows as live in status, and driving that input high removes it.
- R3: Status register 0x80 + 4*group + word returns live & enable[word] & member[group][word]. Enable is at 0x00 + word and membership at 0x40 + 4*group + word. A line that lacks enable or membership never shows.
- R4: A group's pending flag is sampled at the clock edge after its request appears. irq_out is high exactly while some pending group has its bit set in the group mask at 0x10.
- R5: cause_vld and cause_grp, and bits 31 and 3:0 of the cause register at 0x14, give the lowest-numbered pending unmasked group. Masking that group passes the cause to the next pending group at once.
- R6: Cause register bit 30 flags a live line in the chosen group. Bits 22:16 give that line's index, which is the highest index: words are searched from the top down and the highest set bit is taken.
- R7: A group whose bit is set in the level-select register at 0x11 stays pending until a write of its number to 0x13. If the request is still live when that write lands, the group stays pending.
- R8: A group whose level-select bit is clear becomes pending only on a rising edge of its combined request. An acknowledge clears it even if the request is still live, and it stays clear until the next rising edge.
- R9: wake_out is core_sleep AND the OR, over all groups whose bit is set in the group-wake register at 0x12, of live & enable & sleep-wake (0x04 + word) & membership. It follows its inputs with no clock edge.
- R10: Line n sits in word n/32 at bit n%32. For example, line 100 is word 3, bit 4.
- R11: A write of a value that is not a valid group number to 0x13 acknowledges nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq_in | input | 128 | Raw request lines |
| core_sleep | input | 1 | Core is asleep |
| irq_out | output | 1 | Any unmasked group pending |
| wake_out | output | 1 | Wake request while asleep |
| cause_vld | output | 1 | A best group exists |
| cause_grp | output | 4 | Best pending group number |

## Verification
The assertions take three things for granted. A pending group can only disappear through a register write, which is either an acknowledge or a mask change. The wake request can only be seen while core_sleep is high. The reported group is always a legal number. The stimulus respects the bus by changing the write strobe, the address and the request lines only at falling edges. It makes every change to a mask, level select or acknowledge through a write on the register bus, and it never drives core_sleep and a request line so that wake would need a clock to resolve.

// File: rtl/gpi_pkg.sv
package gpi_pkg;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned MAX_WORDS  = 4;
    localparam int unsigned MAX_GROUPS = 15;
    localparam int unsigned GRP_W      = 4;
    localparam int unsigned LINE_W     = 7;
    localparam int unsigned ADDR_W     = 8;

    localparam logic [ADDR_W-1:0] A_ENABLE = 8'h00;
    localparam logic [ADDR_W-1:0] A_WAKEEN = 8'h04;
    localparam logic [ADDR_W-1:0] A_INVERT = 8'h08;
    localparam logic [ADDR_W-1:0] A_GMASK  = 8'h10;
    localparam logic [ADDR_W-1:0] A_GLEVEL = 8'h11;
    localparam logic [ADDR_W-1:0] A_GWAKE  = 8'h12;
    localparam logic [ADDR_W-1:0] A_ACK    = 8'h13;
    localparam logic [ADDR_W-1:0] A_CAUSE  = 8'h14;
    localparam logic [ADDR_W-1:0] A_MEMBER = 8'h40;
    localparam logic [ADDR_W-1:0] A_STATUS = 8'h80;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic             valid;
        logic [GRP_W-1:0] grp;
    } grp_pick_t;

    typedef struct packed {
        logic              valid;
        logic [LINE_W-1:0] idx;
    } line_pick_t;

    // index of the most significant set bit (0 when empty)
    function automatic logic [4:0] top_bit(input word_t v);
        logic [4:0] r;
        r = '0;
        for (int i = 0; i < int'(WORD_W); i++) begin
            if (v[i]) r = 5'(i);
        end
        return r;
    endfunction

    // per-group word address inside a banked region
    function automatic logic [ADDR_W-1:0] bank_addr(input logic [ADDR_W-1:0] base,
                                                   input int g, input int w);
        return base + ADDR_W'(g * int'(MAX_WORDS) + w);
    endfunction

    function automatic word_t pack_cause(input grp_pick_t g, input line_pick_t l);
        word_t r;
        r        = '0;
        r[31]    = g.valid;
        r[30]    = l.valid;
        r[22:16] = l.idx;
        r[3:0]   = g.grp;
        return r;
    endfunction
endpackage

// File: rtl/gpi_regfile.sv
module gpi_regfile
    import gpi_pkg::*;
#(
    parameter int unsigned NUM_WORDS  = 4,
    parameter int unsigned NUM_GROUPS = 15,
    parameter logic [NUM_WORDS*WORD_W-1:0] POL_DEFAULT = '0
) (
    input  logic                                             clk,
    input  logic                                             rst,
    input  logic                                             reg_wr,
    input  logic [ADDR_W-1:0]                                reg_addr,
    input  logic [WORD_W-1:0]                                reg_wdata,
    output logic [WORD_W-1:0]                                reg_rdata,
    input  logic [NUM_GROUPS-1:0][NUM_WORDS-1:0][WORD_W-1:0] status,
    input  logic [WORD_W-1:0]                                cause_word,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]                 en_q,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]                 wken_q,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]                 inv_q,
    output logic [NUM_GROUPS-1:0][NUM_WORDS-1:0][WORD_W-1:0] member_q,
    output logic [NUM_GROUPS-1:0]                            gmask_q,
    output logic [NUM_GROUPS-1:0]                            glevel_q,
    output logic [NUM_GROUPS-1:0]                            gwake_q,
    output logic [NUM_GROUPS-1:0]                            ack_hit
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= '0;
            wken_q   <= '0;
            inv_q    <= POL_DEFAULT;
            member_q <= '0;
            gmask_q  <= '0;
            glevel_q <= '0;
            gwake_q  <= '0;
        end else if (reg_wr) begin
            for (int w = 0; w < int'(NUM_WORDS); w++) begin
                if (reg_addr == A_ENABLE + ADDR_W'(w)) en_q[w]   <= reg_wdata;
                if (reg_addr == A_WAKEEN + ADDR_W'(w)) wken_q[w] <= reg_wdata;
                if (reg_addr == A_INVERT + ADDR_W'(w)) inv_q[w]  <= reg_wdata;
            end
            for (int g = 0; g < int'(NUM_GROUPS); g++) begin
                for (int w = 0; w < int'(NUM_WORDS); w++) begin
                    if (reg_addr == bank_addr(A_MEMBER, g, w)) member_q[g][w] <= reg_wdata;
                end
            end
            if (reg_addr == A_GMASK)  gmask_q  <= reg_wdata[NUM_GROUPS-1:0];
            if (reg_addr == A_GLEVEL) glevel_q <= reg_wdata[NUM_GROUPS-1:0];
            if (reg_addr == A_GWAKE)  gwake_q  <= reg_wdata[NUM_GROUPS-1:0];
        end
    end

    // acknowledge decode: only an exact, in-range group number hits
    always_comb begin
        for (int g = 0; g < int'(NUM_GROUPS); g++) begin
            ack_hit[g] = reg_wr && (reg_addr == A_ACK) && (reg_wdata == WORD_W'(g));
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int w = 0; w < int'(NUM_WORDS); w++) begin
            if (reg_addr == A_ENABLE + ADDR_W'(w)) reg_rdata = en_q[w];
            if (reg_addr == A_WAKEEN + ADDR_W'(w)) reg_rdata = wken_q[w];
            if (reg_addr == A_INVERT + ADDR_W'(w)) reg_rdata = inv_q[w];
        end
        for (int g = 0; g < int'(NUM_GROUPS); g++) begin
            for (int w = 0; w < int'(NUM_WORDS); w++) begin
                if (reg_addr == bank_addr(A_MEMBER, g, w)) reg_rdata = member_q[g][w];
                if (reg_addr == bank_addr(A_STATUS, g, w)) reg_rdata = status[g][w];
            end
        end
        if (reg_addr == A_GMASK)  reg_rdata = WORD_W'(gmask_q);
        if (reg_addr == A_GLEVEL) reg_rdata = WORD_W'(glevel_q);
        if (reg_addr == A_GWAKE)  reg_rdata = WORD_W'(gwake_q);
        if (reg_addr == A_CAUSE)  reg_rdata = cause_word;
    end
endmodule

// File: rtl/gpi_steer.sv
module gpi_steer
    import gpi_pkg::*;
#(
    parameter int unsigned NUM_WORDS  = 4,
    parameter int unsigned NUM_GROUPS = 15,
    localparam int unsigned NUM_LINES = NUM_WORDS * WORD_W
) (
    input  logic [NUM_LINES-1:0]                             irq_in,
    input  logic                                             core_sleep,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0]                 en_q,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0]                 wken_q,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0]                 inv_q,
    input  logic [NUM_GROUPS-1:0][NUM_WORDS-1:0][WORD_W-1:0] member_q,
    input  logic [NUM_GROUPS-1:0]                            gwake_q,
    output logic [NUM_GROUPS-1:0][NUM_WORDS-1:0][WORD_W-1:0] status,
    output logic [NUM_GROUPS-1:0]                            grp_any,
    output logic                                             wake_out
);
    logic [NUM_WORDS-1:0][WORD_W-1:0] live;
    logic [NUM_WORDS-1:0][WORD_W-1:0] wake_src;
    logic [NUM_GROUPS-1:0]            grp_wake;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        assign live[w]     = (irq_in[w*WORD_W +: WORD_W] ^ inv_q[w]) & en_q[w];
        assign wake_src[w] = live[w] & wken_q[w];
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        word_t wake_hit;
        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_mem
            assign status[g][w] = live[w] & member_q[g][w];
        end
        assign grp_any[g] = |status[g];
        always_comb begin
            wake_hit = '0;
            for (int w = 0; w < int'(NUM_WORDS); w++) begin
                wake_hit = wake_hit | (wake_src[w] & member_q[g][w]);
            end
        end
        assign grp_wake[g] = gwake_q[g] & (|wake_hit);
    end

    assign wake_out = core_sleep & (|grp_wake);
endmodule

// File: rtl/gpi_arbiter.sv
module gpi_arbiter
    import gpi_pkg::*;
#(
    parameter int unsigned NUM_WORDS  = 4,
    parameter int unsigned NUM_GROUPS = 15
) (
    input  logic                                             clk,
    input  logic                                             rst,
    input  logic [NUM_GROUPS-1:0]                            grp_any,
    input  logic [NUM_GROUPS-1:0]                            glevel_q,
    input  logic [NUM_GROUPS-1:0]                            gmask_q,
    input  logic [NUM_GROUPS-1:0]                            ack_hit,
    input  logic [NUM_GROUPS-1:0][NUM_WORDS-1:0][WORD_W-1:0] status,
    output grp_pick_t                                        gsel,
    output line_pick_t                                       lsel,
    output logic                                             irq_out
);
    logic [NUM_GROUPS-1:0] pend_q;
    logic [NUM_GROUPS-1:0] seen_q;
    logic [NUM_GROUPS-1:0] trig;
    logic [NUM_GROUPS-1:0] ready;

    // level groups re-arm on any live request, edge groups on a fresh rise
    assign trig  = (grp_any & glevel_q) | (grp_any & ~seen_q & ~glevel_q);
    assign ready = pend_q & gmask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            seen_q <= '0;
        end else begin
            pend_q <= trig | (pend_q & ~ack_hit);
            seen_q <= grp_any;
        end
    end

    // lowest group number wins
    always_comb begin
        gsel = '0;
        for (int g = int'(NUM_GROUPS) - 1; g >= 0; g--) begin
            if (ready[g]) begin
                gsel.valid = 1'b1;
                gsel.grp   = GRP_W'(g);
            end
        end
    end

    // inside the winner: highest word first, then highest bit
    always_comb begin
        lsel = '0;
        for (int g = 0; g < int'(NUM_GROUPS); g++) begin
            if (gsel.valid && gsel.grp == GRP_W'(g)) begin
                for (int w = 0; w < int'(NUM_WORDS); w++) begin
                    if (status[g][w] != '0) begin
                        lsel.valid = 1'b1;
                        lsel.idx   = LINE_W'(w * int'(WORD_W) + int'(top_bit(status[g][w])));
                    end
                end
            end
        end
    end

    assign irq_out = |ready;
endmodule

// File: rtl/gpi_ctrl.sv
module gpi_ctrl
    import gpi_pkg::*;
#(
    parameter int unsigned NUM_WORDS  = 4,
    parameter int unsigned NUM_GROUPS = 15,
    parameter logic [NUM_WORDS*WORD_W-1:0] POL_DEFAULT = '0,
    localparam int unsigned NUM_LINES = NUM_WORDS * WORD_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 core_sleep,
    output logic                 irq_out,
    output logic                 wake_out,
    output logic                 cause_vld,
    output logic [GRP_W-1:0]     cause_grp
);
    logic [NUM_WORDS-1:0][WORD_W-1:0]                 en_q;
    logic [NUM_WORDS-1:0][WORD_W-1:0]                 wken_q;
    logic [NUM_WORDS-1:0][WORD_W-1:0]                 inv_q;
    logic [NUM_GROUPS-1:0][NUM_WORDS-1:0][WORD_W-1:0] member_q;
    logic [NUM_GROUPS-1:0][NUM_WORDS-1:0][WORD_W-1:0] status;
    logic [NUM_GROUPS-1:0] gmask_q;
    logic [NUM_GROUPS-1:0] glevel_q;
    logic [NUM_GROUPS-1:0] gwake_q;
    logic [NUM_GROUPS-1:0] ack_hit;
    logic [NUM_GROUPS-1:0] grp_any;
    grp_pick_t             gsel;
    line_pick_t            lsel;
    word_t                 cause_word;

    gpi_regfile #(
        .NUM_WORDS  (NUM_WORDS),
        .NUM_GROUPS (NUM_GROUPS),
        .POL_DEFAULT(POL_DEFAULT)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .status    (status),
        .cause_word(cause_word),
        .en_q      (en_q),
        .wken_q    (wken_q),
        .inv_q     (inv_q),
        .member_q  (member_q),
        .gmask_q   (gmask_q),
        .glevel_q  (glevel_q),
        .gwake_q   (gwake_q),
        .ack_hit   (ack_hit)
    );

    gpi_steer #(
        .NUM_WORDS (NUM_WORDS),
        .NUM_GROUPS(NUM_GROUPS)
    ) u_steer (
        .irq_in    (irq_in),
        .core_sleep(core_sleep),
        .en_q      (en_q),
        .wken_q    (wken_q),
        .inv_q     (inv_q),
        .member_q  (member_q),
        .gwake_q   (gwake_q),
        .status    (status),
        .grp_any   (grp_any),
        .wake_out  (wake_out)
    );

    gpi_arbiter #(
        .NUM_WORDS (NUM_WORDS),
        .NUM_GROUPS(NUM_GROUPS)
    ) u_arb (
        .clk     (clk),
        .rst     (rst),
        .grp_any (grp_any),
        .glevel_q(glevel_q),
        .gmask_q (gmask_q),
        .ack_hit (ack_hit),
        .status  (status),
        .gsel    (gsel),
        .lsel    (lsel),
        .irq_out (irq_out)
    );

    assign cause_word = pack_cause(gsel, lsel);
    assign cause_vld  = gsel.valid;
    assign cause_grp  = gsel.grp;
endmodule

// File: rtl/gpi_checker.sv
module gpi_checker (
    input logic       clk,
    input logic       rst,
    input logic       reg_wr,
    input logic       irq_out,
    input logic       wake_out,
    input logic       core_sleep,
    input logic       cause_vld,
    input logic [3:0] cause_grp
);
    logic rst_q;

    always_ff @(posedge clk) rst_q <= rst;

    // R1: first edge out of reset sees nothing pending
    always_ff @(posedge clk) begin
        if (rst_q && !rst) begin
            p_quiet_after_reset_r1: assert (!irq_out && !cause_vld)
                else $error("pending state survived reset");
        end
    end

    // R4: the interrupt output and the cause valid come from separate logic
    p_irq_matches_cause_r4: assert property (@(posedge clk) disable iff (rst)
        irq_out == cause_vld);

    // R5: reported group is always a legal number
    p_group_in_range_r5: assert property (@(posedge clk) disable iff (rst)
        cause_vld |-> (int'(cause_grp) < int'(gpi_pkg::MAX_GROUPS)));

    // R7: an asserted interrupt only goes away through a register write
    p_hold_until_write_r7: assert property (@(posedge clk) disable iff (rst)
        (irq_out && !reg_wr) |=> irq_out);

    // R9: wake is only requested while the core sleeps
    p_wake_needs_sleep_r9: assert property (@(posedge clk) disable iff (rst)
        wake_out |-> core_sleep);
endmodule

bind gpi_ctrl gpi_checker u_gpi_checker (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .irq_out   (irq_out),
    .wake_out  (wake_out),
    .core_sleep(core_sleep),
    .cause_vld (cause_vld),
    .cause_grp (cause_grp)
);

// File: tb/gpi_ctrl_bench.sv
module gpi_ctrl_bench;
    logic         clk = 1'b0;
    logic         rst;
    logic         reg_wr;
    logic [7:0]   reg_addr;
    logic [31:0]  reg_wdata;
    logic [31:0]  reg_rdata;
    logic [127:0] irq_in;
    logic         core_sleep;
    logic         irq_out;
    logic         wake_out;
    logic         cause_vld;
    logic [3:0]   cause_grp;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam int K_RDATA = 0;
    localparam int K_IRQ   = 1;
    localparam int K_WAKE  = 2;
    localparam int K_CVLD  = 3;
    localparam int K_CGRP  = 4;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    always #4 clk = ~clk;

    gpi_ctrl u_gpi_ctrl (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_in    (irq_in),
        .core_sleep(core_sleep),
        .irq_out   (irq_out),
        .wake_out  (wake_out),
        .cause_vld (cause_vld),
        .cause_grp (cause_grp)
    );

    // monitor: compares queued expectations shortly after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.kind)
                    K_RDATA: act = reg_rdata;
                    K_IRQ:   act = {31'b0, irq_out};
                    K_WAKE:  act = {31'b0, wake_out};
                    K_CVLD:  act = {31'b0, cause_vld};
                    default: act = {28'b0, cause_grp};
                endcase
                n_tests++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic expect_port(input int kind, input logic [31:0] e, input string tag);
        item_t it;
        it.kind = kind; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic expect_reg(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        reg_addr = a;
        it.kind = K_RDATA; it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        irq_in = '0; core_sleep = 1'b0;
        tick(3);
        rst = 1'b0;

        // R1 reset state
        expect_port(K_IRQ,  0, "R1 irq_out");
        expect_port(K_CVLD, 0, "R1 cause_vld");
        expect_reg(8'h00, 32'h0, "R1 enable w0");
        expect_reg(8'h07, 32'h0, "R1 wake-en w3");
        expect_reg(8'h58, 32'h0, "R1 member g6w0");
        expect_reg(8'h0B, 32'h0, "R1 inversion w3 default");
        expect_reg(8'h10, 32'h0, "R1 group mask");
        expect_reg(8'h14, 32'h0, "R1 cause");

        wr(8'h10, 32'h7FFF);
        wr(8'h11, 32'h7FFF);
        wr(8'h12, 32'h7FFF);

        // R3 gating by membership and enable
        irq_in[5] = 1'b1;
        expect_reg(8'h98, 32'h0, "R3 no member no enable");
        wr(8'h58, 32'h20);
        expect_reg(8'h98, 32'h0, "R3 member without enable");
        wr(8'h00, 32'h20);
        expect_port(K_IRQ, 0, "R4 not yet latched");
        expect_reg(8'h98, 32'h20, "R3 status g6w0");
        expect_port(K_IRQ,  1, "R4 irq one edge later");
        expect_port(K_CGRP, 6, "R5 group 6");
        expect_reg(8'h14, 32'hC005_0006, "R6 cause line 5");

        // R10 line 100 -> word 3 bit 4, in group 12
        wr(8'h73, 32'h10);
        wr(8'h03, 32'h10);
        irq_in[100] = 1'b1;
        tick(2);
        expect_reg(8'hB3, 32'h10, "R10 line 100 at w3 bit4");
        expect_reg(8'h9B, 32'h0, "R3 g6w3 excludes line 100");
        expect_port(K_CGRP, 6, "R5 lower group wins");

        // R6 highest line across words in group 6
        wr(8'h59, 32'h100);
        wr(8'h5A, 32'h40);
        wr(8'h01, 32'h100);
        wr(8'h02, 32'h40);
        irq_in[40] = 1'b1;
        irq_in[70] = 1'b1;
        tick(2);
        expect_reg(8'h14, 32'hC046_0006, "R6 line 70 wins");

        // R5 masking passes the cause on
        wr(8'h10, 32'h7FBF);
        expect_port(K_CGRP, 12, "R5 masked g6");
        expect_reg(8'h14, 32'hC064_000C, "R5 cause g12 line 100");
        wr(8'h10, 32'h7FFF);

        // R7 level acknowledge
        wr(8'h13, 32'd6);
        expect_port(K_CGRP, 6, "R7 ack with live source re-pends");
        expect_port(K_IRQ,  1, "R7 irq stays");
        tick(1);
        irq_in[5] = 1'b0; irq_in[40] = 1'b0; irq_in[70] = 1'b0;
        tick(2);
        expect_port(K_CGRP, 6, "R7 held after source drop");
        expect_reg(8'h14, 32'h8000_0006, "R6 no live line in held group");
        wr(8'h13, 32'd6);
        expect_port(K_CGRP, 12, "R7 ack clears");

        // R11 out-of-range acknowledge
        wr(8'h13, 32'd15);
        expect_port(K_CGRP, 12, "R11 ack 15 ignored");
        expect_port(K_IRQ,  1, "R11 irq kept");
        tick(1);

        // R2 inversion
        wr(8'h48, 32'h08);
        wr(8'h00, 32'h28);
        expect_reg(8'h88, 32'h0, "R2 raw low not inverted");
        wr(8'h08, 32'h08);
        expect_reg(8'h88, 32'h08, "R2 inverted low is live");
        expect_port(K_CGRP, 2, "R2 group 2 pends");
        irq_in[3] = 1'b1;
        expect_reg(8'h88, 32'h0, "R2 inverted high not live");
        wr(8'h13, 32'd2);
        expect_port(K_CGRP, 12, "R2 after ack");
        tick(1);

        // R8 edge mode on group 12
        wr(8'h11, 32'h6FFF);
        wr(8'h13, 32'd12);
        expect_port(K_IRQ,  0, "R8 ack clears with live source");
        expect_port(K_CVLD, 0, "R8 no cause");
        tick(2);
        expect_port(K_IRQ, 0, "R8 no re-pend without edge");
        tick(1);
        irq_in[100] = 1'b0;
        tick(1);
        irq_in[100] = 1'b1;
        expect_port(K_IRQ, 0, "R8 rise not yet sampled");
        tick(1);
        expect_port(K_IRQ,  1, "R8 rise re-pends");
        expect_port(K_CGRP, 12, "R8 group 12");
        tick(1);

        // R9 wake path
        wr(8'h07, 32'h10);
        expect_port(K_WAKE, 0, "R9 awake core");
        tick(1);
        core_sleep = 1'b1;
        expect_port(K_WAKE, 1, "R9 sleep wakes");
        tick(1);
        wr(8'h12, 32'h6FFF);
        expect_port(K_WAKE, 0, "R9 group wake mask");
        tick(1);
        wr(8'h12, 32'h7FFF);
        expect_port(K_WAKE, 1, "R9 mask restored");
        tick(1);
        irq_in[100] = 1'b0;
        irq_in[5]   = 1'b1;
        expect_port(K_WAKE, 0, "R9 line without wake enable");
        tick(2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule